// File: doc/BRIEF.md
# Five-Phase Full-Step Commutation Sequencer

This block turns step and direction commands into the full-step commutation pattern for a five-wire, five-phase stepper bridge. It holds a position index that runs from 0 to 9 and repeats. Each rising edge on the step input moves the index one place. The direction input chooses whether the index counts up or down. From the index the block derives two output sets. The first is five winding levels, in which a single winding toggles on every step. The second is ten bridge switch enables, five on the high side and five on the low side, in which exactly three switches conduct at any step.

A mode input picks which output set is live; the other set is held at zero. A drive-enable input forces every switch enable off. While drive is disabled the index still follows step pulses, so drive resumes at the commanded position. All outputs come from registers, so the bridge never sees a combinational glitch. An output reflects the index one clock after the index moves. All inputs are taken to be synchronous to `clk`.

Top module: `fph_gate_seq`

## Requirements
- R1: While `rst_n` is low, all outputs are 0 and the index is 0. On the first clock after release, in winding mode, `wind_o` shows the step-0 pattern 5'b11100.
- R2: Only a 0-to-1 transition of `step_in` (sampled on `clk`) moves the index, by exactly one place. Holding `step_in` high for any number of cycles has no further effect.
- R3: When `dir_fwd` is 1 the index increments, and 9 wraps to 0. When `dir_fwd` is 0 the index decrements, and 0 wraps to 9. The index never leaves 0..9.
- R4: In winding mode, bit p of `wind_o` (p = 0..4) is high for the five index values starting at (2 + 2p) mod 10 and low for the other five. Bit 0 is therefore low at 0-1, high at 2-6 and low at 7-9.
- R5: In winding mode, each index move changes exactly one bit of `wind_o`.
- R6: In gate mode with drive enabled, `hs_o[x]` (bit 0 = winding A through bit 4 = E) is on for the three index values starting at (2x - 1) mod 10. `ls_o[x]` is on for the three index values starting at (2x + 4) mod 10. A high-side and a low-side enable of the same winding are never on together.
- R7: In gate mode with drive enabled, exactly three of the ten bits of {`hs_o`, `ls_o`} are 1 at every index value.
- R8: With `drive_en` low, `hs_o` and `ls_o` are 0 from the next clock on. The index keeps following step pulses while drive is disabled.
- R9: `mode_gate` = 0 selects winding mode, in which `hs_o` and `ls_o` are 0. `mode_gate` = 1 selects gate mode, in which `wind_o` is 0.
- R10: Outputs are registered. A step edge sampled at clock k moves the index at k, and the outputs show the new index from clock k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step_in | input | 1 | Step command; its rising edge moves the index |
| dir_fwd | input | 1 | 1 = count up, 0 = count down |
| mode_gate | input | 1 | 0 = winding-level outputs, 1 = switch-enable outputs |
| drive_en | input | 1 | 0 forces all switch enables off |
| wind_o | output | 5 | Winding levels, bit p = phase p |
| hs_o | output | 5 | High-side switch enables, bit 0 = A .. bit 4 = E |
| ls_o | output | 5 | Low-side switch enables, bit 0 = A .. bit 4 = E |

## Verification
The assertions assume that `step_in`, `dir_fwd`, `mode_gate` and `drive_en` change only between clock edges and never during reset release. The one-winding-change property further assumes that the mode has been steady for two samples, because a mode switch legitimately changes several winding bits at once. The stimulus drives every input on the falling clock edge, holds `step_in` low through reset, and makes each mode change only while no step pulse is in flight. Outputs are therefore checked only against index moves, and never against a mode boundary.

// File: rtl/fph_pkg.sv
package fph_pkg;
  localparam int unsigned PHASES  = 5;
  localparam int unsigned STEPS   = 2 * PHASES;
  localparam int unsigned IDX_W   = $clog2(STEPS);
  localparam int unsigned WIND_ON = PHASES;
  localparam int unsigned GATE_ON = 3;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [PHASES-1:0] lane_t;

  typedef enum logic {
    MODE_WIND = 1'b0,
    MODE_GATE = 1'b1
  } mode_e;

  // True when index s lies in the circular window [start, start+len) mod STEPS.
  function automatic logic in_window(idx_t s, int unsigned start, int unsigned len);
    int d;
    d = int'(s) - int'(start % STEPS);
    if (d < 0) d = d + int'(STEPS);
    return (d < int'(len));
  endfunction
endpackage

// File: rtl/fph_step_edge.sv
module fph_step_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic adv_o
);
  logic step_q;
  logic step_d;

  always_comb begin
    step_d = step_i;
    adv_o  = step_i & ~step_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= 1'b0;
    else        step_q <= step_d;
  end

  // R2: an advance pulse never lasts more than one cycle
  assert_single_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |=> !adv_o);
endmodule

// File: rtl/fph_step_index.sv
module fph_step_index
  import fph_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic fwd_i,
  output idx_t idx_o
);
  localparam idx_t LAST = idx_t'(STEPS - 1);

  idx_t idx_q;
  idx_t idx_d;
  logic idx_en;

  always_comb begin
    idx_en = adv_i;
    idx_d  = idx_q;
    if (fwd_i) idx_d = (idx_q == LAST) ? '0 : idx_q + idx_t'(1);
    else       idx_d = (idx_q == '0) ? LAST : idx_q - idx_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  // R3: the index stays inside the ten-step cycle
  assert_index_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);
  // R2: with no advance pulse the index holds
  assert_index_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(idx_q));
  // R2: an advance pulse always moves the index
  assert_index_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> !$stable(idx_q));
endmodule

// File: rtl/fph_phase_map.sv
module fph_phase_map
  import fph_pkg::*;
(
  input  idx_t  idx_i,
  output lane_t wind_o
);
  for (genvar p = 0; p < int'(PHASES); p++) begin : g_phase
    localparam int unsigned START = 2 + 2 * p;
    assign wind_o[p] = in_window(idx_i, START, WIND_ON);
  end
endmodule

// File: rtl/fph_gate_map.sv
module fph_gate_map
  import fph_pkg::*;
(
  input  idx_t  idx_i,
  output lane_t hs_o,
  output lane_t ls_o
);
  for (genvar x = 0; x < int'(PHASES); x++) begin : g_leg
    localparam int unsigned HS_START = 2 * x + STEPS - 1;
    localparam int unsigned LS_START = 2 * x + PHASES - 1;
    assign hs_o[x] = in_window(idx_i, HS_START, GATE_ON);
    assign ls_o[x] = in_window(idx_i, LS_START, GATE_ON);
  end
endmodule

// File: rtl/fph_gate_seq.sv
module fph_gate_seq
  import fph_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_in,
  input  logic       dir_fwd,
  input  logic       mode_gate,
  input  logic       drive_en,
  output logic [4:0] wind_o,
  output logic [4:0] hs_o,
  output logic [4:0] ls_o
);
  logic  adv;
  idx_t  idx;
  lane_t wind_map, hs_map, ls_map;
  lane_t wind_d, hs_d, ls_d;
  lane_t wind_q, hs_q, ls_q;
  mode_e mode;
  logic  out_en;
  logic [1:0] settle_q;

  fph_step_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (step_in),
    .adv_o  (adv)
  );

  fph_step_index u_index (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (adv),
    .fwd_i (dir_fwd),
    .idx_o (idx)
  );

  fph_phase_map u_phase (
    .idx_i  (idx),
    .wind_o (wind_map)
  );

  fph_gate_map u_gate (
    .idx_i (idx),
    .hs_o  (hs_map),
    .ls_o  (ls_map)
  );

  always_comb begin
    mode   = mode_e'(mode_gate);
    out_en = 1'b1;
    wind_d = (mode == MODE_WIND) ? wind_map : '0;
    hs_d   = (mode == MODE_GATE && drive_en) ? hs_map : '0;
    ls_d   = (mode == MODE_GATE && drive_en) ? ls_map : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wind_q   <= '0;
      hs_q     <= '0;
      ls_q     <= '0;
      settle_q <= '0;
    end else if (out_en) begin
      wind_q   <= wind_d;
      hs_q     <= hs_d;
      ls_q     <= ls_d;
      settle_q <= {settle_q[0], 1'b1};
    end
  end

  assign wind_o = wind_q;
  assign hs_o   = hs_q;
  assign ls_o   = ls_q;

  // R5: with the mode steady, winding outputs change one bit at a time
  assert_one_winding_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q[1] && !$past(mode_gate) && !$past(mode_gate, 2) && (wind_o != $past(wind_o)))
      |-> ($countones(wind_o ^ $past(wind_o)) == 1));
  // R7: three switches conduct in enabled gate mode
  assert_three_switches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q[0] && $past(mode_gate) && $past(drive_en))
      |-> ($countones({hs_o, ls_o}) == 3));
  // R6: no leg ever has both switches on
  assert_no_shoot_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_o & ls_o) == '0);
  // R8: disabled drive leaves every switch off
  assert_drive_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(drive_en) |-> (hs_o == '0 && ls_o == '0));
  // R9: only the selected output set is live
  assert_wind_mode_gates_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode_gate) |-> (hs_o == '0 && ls_o == '0));
  assert_gate_mode_wind_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_gate) |-> (wind_o == '0));
endmodule

// File: tb/tb_fph_gate_seq.sv
module tb_fph_gate_seq;
  logic clk = 1'b0;
  logic rst_n, step_in, dir_fwd, mode_gate, drive_en;
  logic [4:0] wind_o, hs_o, ls_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit live_cmp = 1'b0;
  bit done = 1'b0;

  // Tables written from R4 and R6 (wind bit p = phase p; gate bit 0 = A)
  logic [4:0] WT [10] = '{5'h1C, 5'h18, 5'h19, 5'h11, 5'h13,
                          5'h03, 5'h07, 5'h06, 5'h0E, 5'h0C};
  logic [4:0] HT [10] = '{5'h01, 5'h03, 5'h02, 5'h06, 5'h04,
                          5'h0C, 5'h08, 5'h18, 5'h10, 5'h11};
  logic [4:0] LT [10] = '{5'h0C, 5'h08, 5'h18, 5'h10, 5'h11,
                          5'h01, 5'h03, 5'h02, 5'h06, 5'h04};

  int m_idx;
  bit m_sq;
  logic [4:0] e_w, e_h, e_l;

  always #5 clk = ~clk;

  fph_gate_seq dut (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_fwd(dir_fwd),
    .mode_gate(mode_gate), .drive_en(drive_en),
    .wind_o(wind_o), .hs_o(hs_o), .ls_o(ls_o)
  );

  // Behavioural reference: outputs follow the previous index (R10)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_sq = 1'b0; e_w = '0; e_h = '0; e_l = '0;
    end else begin
      e_w = mode_gate ? 5'h00 : WT[m_idx];
      e_h = (mode_gate && drive_en) ? HT[m_idx] : 5'h00;
      e_l = (mode_gate && drive_en) ? LT[m_idx] : 5'h00;
      if (step_in && !m_sq) m_idx = dir_fwd ? (m_idx + 1) % 10 : (m_idx + 9) % 10;
      m_sq = step_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (live_cmp) begin
      chk("R4 R6 R9 R10 wind vs model", {27'd0, wind_o}, {27'd0, e_w});
      chk("R6 R8 R9 high side vs model", {27'd0, hs_o}, {27'd0, e_h});
      chk("R6 R8 R9 low side vs model", {27'd0, ls_o}, {27'd0, e_l});
    end
    if (cycles > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // One pulse; returns once the outputs show the new index
  task automatic pulse(output logic [4:0] w_mid);
    @(negedge clk) step_in = 1'b1;
    @(negedge clk) step_in = 1'b0;
    w_mid = wind_o;
    @(negedge clk);
  endtask

  initial begin
    logic [4:0] prev, mid;
    int exp_idx;
    rst_n = 1'b0; step_in = 1'b0; dir_fwd = 1'b1; mode_gate = 1'b0; drive_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {17'd0, wind_o, hs_o, ls_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    live_cmp = 1'b1;
    chk("R1 step0 winding", {27'd0, wind_o}, 32'h1C);
    exp_idx = 0;

    // Forward through a full cycle plus wrap
    for (int i = 0; i < 12; i++) begin
      prev = wind_o;
      pulse(mid);
      exp_idx = (exp_idx + 1) % 10;
      chk("R10 output still old one cycle after edge", {27'd0, mid}, {27'd0, prev});
      chk("R4 R3 winding forward", {27'd0, wind_o}, {27'd0, WT[exp_idx]});
      chk("R5 one bit change", $countones(wind_o ^ prev), 32'd1);
      chk("R9 gates off in winding mode", {22'd0, hs_o, ls_o}, 32'd0);
    end

    // Held step: no further movement
    prev = wind_o;
    @(negedge clk) step_in = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 held step moves once", {27'd0, wind_o}, {27'd0, WT[(exp_idx + 1) % 10]});
    exp_idx = (exp_idx + 1) % 10;
    step_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 release does not move", {27'd0, wind_o}, {27'd0, WT[exp_idx]});

    // Reverse across the 0 -> 9 wrap
    dir_fwd = 1'b0;
    for (int i = 0; i < 5; i++) begin
      prev = wind_o;
      pulse(mid);
      exp_idx = (exp_idx + 9) % 10;
      chk("R3 winding reverse", {27'd0, wind_o}, {27'd0, WT[exp_idx]});
      chk("R5 one bit change reverse", $countones(wind_o ^ prev), 32'd1);
    end

    // Gate mode, full forward cycle
    dir_fwd = 1'b1;
    @(negedge clk) mode_gate = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 winding off in gate mode", {27'd0, wind_o}, 32'd0);
    for (int i = 0; i < 10; i++) begin
      chk("R6 high side table", {27'd0, hs_o}, {27'd0, HT[exp_idx]});
      chk("R6 low side table", {27'd0, ls_o}, {27'd0, LT[exp_idx]});
      chk("R7 three switches", $countones({hs_o, ls_o}), 32'd3);
      pulse(mid);
      exp_idx = (exp_idx + 1) % 10;
    end

    // Drive disable: switches off, index still tracks
    @(negedge clk) drive_en = 1'b0;
    @(negedge clk);
    chk("R8 switches off", {22'd0, hs_o, ls_o}, 32'd0);
    pulse(mid); pulse(mid); pulse(mid);
    exp_idx = (exp_idx + 3) % 10;
    chk("R8 still off after steps", {22'd0, hs_o, ls_o}, 32'd0);
    @(negedge clk) drive_en = 1'b1;
    @(negedge clk);
    chk("R8 resumes at tracked high side", {27'd0, hs_o}, {27'd0, HT[exp_idx]});
    chk("R8 resumes at tracked low side", {27'd0, ls_o}, {27'd0, LT[exp_idx]});

    // Reverse in gate mode across wrap
    dir_fwd = 1'b0;
    for (int i = 0; i < 6; i++) begin
      pulse(mid);
      exp_idx = (exp_idx + 9) % 10;
      chk("R3 R6 gate reverse high", {27'd0, hs_o}, {27'd0, HT[exp_idx]});
      chk("R3 R6 gate reverse low", {27'd0, ls_o}, {27'd0, LT[exp_idx]});
    end

    // Back to winding mode, then reset mid-sequence
    @(negedge clk) mode_gate = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 back to winding", {27'd0, wind_o}, {27'd0, WT[exp_idx]});
    live_cmp = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", {17'd0, wind_o, hs_o, ls_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    live_cmp = 1'b1;
    chk("R1 index back to 0", {27'd0, wind_o}, 32'h1C);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule